// File: doc/BRIEF.md
# Instruction Indirection Stage

This stage sits between instruction fetch and the decoder of a 32-bit core and hides part of the program behind a lookup. Each fetched word does two things in the same cycle. It addresses a fixed 1024-entry, 32-bit synchronous table, and it is captured in a holding register. One cycle later the stage checks the held word. If its major opcode equals a reserved reference value, the decoder receives the table entry that the word selected. Otherwise the decoder receives the held word unchanged.

The table is a read-only parameter array, fixed when the circuit is built. Several indices may hold the same instruction. Each reference word still resolves to exactly one instruction. A stall input freezes the table read and the holding register together, so the decoder sees the same word for as long as the stall lasts. The choice of table contents and any instruction packing are not part of this block.

Top module: `instr_indirect_stage`

## Requirements
- R1: While reset is asserted, and after it until the first fetched word is captured, `instr_o` is the all-zero word.
- R2: A fetched word whose bits [31:26] differ from `REF_OPC` (default 6'h3E), taken in a cycle without stall, appears unchanged on `instr_o` after the next rising clock edge.
- R3: A fetched word whose bits [31:26] equal `REF_OPC`, taken in a cycle without stall, is replaced on `instr_o` after the next rising edge by `TABLE[w[9:0]]`.
- R4: In a cycle with `stall_i` high, the fetched word is discarded and `instr_o` keeps its previous value across the following edge.
- R5: For a reference word, bits [25:10] have no effect on the translated output. Only bits [9:0] select the entry.
- R6: The table may hold the same instruction at several indices. With the default contents, indices i and i+768 (i < 256) translate to identical words.
- R7: Reference and plain words may arrive on consecutive cycles. Each one is resolved one cycle after capture, with no bubble, including the boundary indices 0 and 1023.
- R8: Table contents come only from the `TABLE` parameter. The default is the package function `iis_pkg::default_table()`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Pipeline stall; freezes table read and holding register |
| fetch_i | input | 32 | Instruction word from fetch |
| instr_o | output | 32 | Resolved instruction to the decoder |

## Verification
A fault in the holding register or the table output register becomes visible on `instr_o` one edge after the word concerned is fetched. It shows up either as the wrong word or as a word from a neighbouring cycle. A select fault inverts the choice between raw and translated words, which appears on the very first reference word or plain word. A stall fault shows as a change of output during a stall, or as a discarded word leaking out afterwards. The bench compares every cycle against a behavioural model, so each of these faults is caught within one cycle of its cause.

// File: rtl/iis_pkg.sv
package iis_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned DUP_SPAN = 768;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t table_t [DEPTH];

  // Entries repeat every DUP_SPAN indices, giving duplicated instructions.
  function automatic table_t default_table();
    table_t t;
    for (int k = 0; k < DEPTH; k++) begin
      word_t j;
      j = word_t'(k % DUP_SPAN);
      t[k] = (j * 32'h045D_9F3B) ^ 32'hA5C3_0F1E;
    end
    return t;
  endfunction
endpackage

// File: rtl/iis_table.sv
module iis_table #(
  parameter iis_pkg::table_t TABLE = iis_pkg::default_table()
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic [iis_pkg::IDX_W-1:0]    addr_i,
  output iis_pkg::word_t               data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (en_i) data_o <= TABLE[addr_i];
  end
endmodule

// File: rtl/iis_capture.sv
module iis_capture (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  iis_pkg::word_t d_i,
  output iis_pkg::word_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/iis_select.sv
module iis_select #(
  parameter logic [iis_pkg::OPC_W-1:0] REF_OPC = 6'h3E
) (
  input  iis_pkg::word_t held_i,
  input  iis_pkg::word_t tbl_i,
  output iis_pkg::word_t instr_o
);
  localparam int unsigned OPC_LO = iis_pkg::WORD_W - iis_pkg::OPC_W;
  logic is_ref;
  always_comb begin
    is_ref  = (held_i[iis_pkg::WORD_W-1:OPC_LO] == REF_OPC);
    instr_o = is_ref ? tbl_i : held_i;
  end
endmodule

// File: rtl/instr_indirect_stage.sv
module instr_indirect_stage #(
  parameter logic [iis_pkg::OPC_W-1:0] REF_OPC = 6'h3E,
  parameter iis_pkg::table_t TABLE = iis_pkg::default_table()
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stall_i,
  input  logic [31:0] fetch_i,
  output logic [31:0] instr_o
);
  logic           en;
  iis_pkg::word_t held_q, tbl_q;

  assign en = ~stall_i;

  iis_table #(.TABLE(TABLE)) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .addr_i (fetch_i[iis_pkg::IDX_W-1:0]),
    .data_o (tbl_q)
  );

  iis_capture u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .d_i    (fetch_i),
    .q_o    (held_q)
  );

  iis_select #(.REF_OPC(REF_OPC)) u_select (
    .held_i  (held_q),
    .tbl_i   (tbl_q),
    .instr_o (instr_o)
  );
endmodule

// File: rtl/iis_checks.sv
module iis_checks #(
  parameter logic [5:0] REF_OPC = 6'h3E,
  parameter iis_pkg::table_t TABLE = iis_pkg::default_table()
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        stall_i,
  input logic [31:0] fetch_i,
  input logic [31:0] instr_o
);
  // R1: output is zero while in reset
  always_comb begin
    if (!rst_ni) a_r1_reset_zero: assert (instr_o == 32'h0);
  end

  // R4: stall holds the output
  a_r4_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(instr_o));

  // R2: plain word passes through one cycle later
  a_r2_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && fetch_i[31:26] != REF_OPC) |=> instr_o == $past(fetch_i));

  // R3: reference word resolves through the table one cycle later
  a_r3_translate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && fetch_i[31:26] == REF_OPC) |=> instr_o == TABLE[$past(fetch_i[9:0])]);
endmodule

bind instr_indirect_stage iis_checks #(.REF_OPC(REF_OPC), .TABLE(TABLE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .stall_i (stall_i),
  .fetch_i (fetch_i),
  .instr_o (instr_o)
);

// File: tb/instr_indirect_stage_test.sv
module instr_indirect_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] REF = 6'h3E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [31:0] fetch = 32'h0;
  logic [31:0] instr;

  int checks = 0;
  int errors = 0;

  iis_pkg::table_t tbl;
  logic [31:0] model_word;
  logic [31:0] seen_a;
  logic [31:0] lfsr;
  bit          done = 1'b0;

  instr_indirect_stage #(.REF_OPC(REF)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .stall_i (stall),
    .fetch_i (fetch),
    .instr_o (instr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] expect_of(logic [31:0] w);
    if (w[31:26] == REF) return tbl[w[9:0]];
    return w;
  endfunction

  function automatic logic [31:0] mk_ref(int idx, logic [15:0] mid);
    return {REF, mid, idx[9:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle, then at the next falling edge compare against the model.
  task automatic step(logic [31:0] w, logic st, string req);
    fetch = w;
    stall = st;
    @(negedge clk);
    if (!st) model_word = w;
    check(req, instr, expect_of(model_word));
  endtask

  initial begin
    tbl = iis_pkg::default_table();
    model_word = 32'h0;
    repeat (3) @(negedge clk);
    check("R1 in reset", instr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", instr, 32'h0);

    // R2: plain words
    step(32'h2402_0005, 1'b0, "R2 plain");
    step(32'hFFFF_FFFF, 1'b0, "R2 plain ones");
    step(32'h0000_0000, 1'b0, "R2 plain zero");
    step(32'hF400_0123, 1'b0, "R2 opcode 3D");

    // R3 / R7: reference words, boundaries, back to back
    step(mk_ref(0, 16'h0), 1'b0, "R3 idx0");
    check("R7 idx0 value", instr, tbl[0]);
    step(mk_ref(1023, 16'h0), 1'b0, "R7 idx1023");
    check("R7 idx1023 value", instr, tbl[1023]);
    step(mk_ref(500, 16'h0), 1'b0, "R3 idx500");
    step(32'h0123_4567, 1'b0, "R7 plain after ref");
    step(mk_ref(17, 16'h0), 1'b0, "R7 ref after plain");

    // R5: middle bits ignored
    step(mk_ref(42, 16'hFFFF), 1'b0, "R5 mid ones");
    seen_a = instr;
    step(mk_ref(42, 16'h5A3C), 1'b0, "R5 mid pattern");
    check("R5 same entry", instr, seen_a);

    // R6: duplicated entries
    step(mk_ref(5, 16'h0), 1'b0, "R6 idx5");
    seen_a = instr;
    step(mk_ref(5 + 768, 16'h0), 1'b0, "R6 idx773");
    check("R6 duplicate equal", instr, seen_a);
    check("R8 parameter table", instr, tbl[773]);

    // R4: stall holds output and discards the stalled word
    step(32'h1111_2222, 1'b0, "R4 before stall");
    seen_a = instr;
    step(mk_ref(9, 16'h0), 1'b1, "R4 stall ref");
    check("R4 hold ref", instr, seen_a);
    step(32'h3333_4444, 1'b1, "R4 stall plain");
    check("R4 hold plain", instr, seen_a);
    step(32'h5555_6666, 1'b0, "R4 release");
    check("R4 discarded", instr, 32'h5555_6666);
    step(mk_ref(300, 16'h0), 1'b0, "R4 ref before stall");
    seen_a = instr;
    step(32'h7777_8888, 1'b1, "R4 stall after ref");
    check("R4 hold translated", instr, seen_a);

    // Mixed traffic against the model
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = lfsr;
      if (lfsr[3:2] != 2'b00) w[31:26] = REF;
      step(w, lfsr[7:5] == 3'b000, "R7 mixed");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule